// File: doc/BRIEF.md
# Interrupt Source Bank with Edge and Level Sources

This block holds a bank of interrupt sources and turns their input activity into offers to a downstream presentation controller. Each source is strapped as edge (message-style) or level type. Each source holds a target server number, a priority, a saved priority and four status flags: masked-pending, rejected, asserted and sent. A priority of all ones masks the source. The global interrupt number of a source is its local index plus the `BASE_NUM` parameter (default 0x1000).

The presenter answers through three channels, all addressed by global number: reject, end-of-interrupt and replay. A reject returns an offer it could not take. An end-of-interrupt completes a level interrupt. A replay request makes the bank scan every source, one per cycle, and re-offer what is still outstanding. When several offers arise in the same cycle, they wait in a per-source pending bitmap. They leave one per cycle through a valid/number/server/priority port, lowest index first.

Top module: `irq_source_bank`

## Requirements
- R1: After reset no offer is issued, `replay_done_o` is low, every priority and saved priority is 0xFF (masked), servers are 0 and all status flags are clear. A masked level source held high produces no offer.
- R2: An edge source with priority other than 0xFF offers one interrupt for each cycle its `irq_i` bit is high. The offer appears on `offer_valid_o` two clock edges after the input is sampled and carries `offer_num_o` = BASE_NUM + index, the stored server and the stored priority.
- R3: An edge event on a masked source sets masked-pending and issues no offer. A configuration write with priority other than 0xFF clears the flag and issues one offer. A write with priority 0xFF leaves the flag set and issues no offer.
- R4: A level source is checked when its input changes, when it receives a configuration write or when the replay scan visits it. The check offers it and sets sent only if the source is unmasked, asserted and not already sent. It is never re-offered while sent.
- R5: A reject of an edge source sets rejected and causes no offer. A reject of a level source clears sent and causes no offer until the next check of R4.
- R6: End-of-interrupt clears sent on a level source, so the next check of R4 can offer it again. On an edge source it has no effect.
- R7: `replay_i` pulsed while idle starts a scan that visits index 0 up to NUM_SRC-1, one per cycle. `replay_done_o` pulses for one cycle 9 edges after the request with 8 sources. A visited edge source with rejected set has the flag cleared and is re-offered only if unmasked; if masked, the event is dropped.
- R8: Offers that arise in the same cycle are issued on consecutive cycles in ascending source index.
- R9: A configuration write (`cfg_we_i`, local index `cfg_idx_i`) stores server, priority and saved priority. The stored server and priority are used by later offers.
- R10: Reject and end-of-interrupt numbers below BASE_NUM or at or above BASE_NUM+NUM_SRC change no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_mode_i | input | NUM_SRC | Per-source type strap: 1 level, 0 edge |
| irq_i | input | NUM_SRC | Edge: high cycle is an event; level: input level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local source index for the write |
| cfg_server_i | input | SRV_W | Server number to store |
| cfg_prio_i | input | PRIO_W | Priority to store (0xFF masks) |
| cfg_saved_i | input | PRIO_W | Saved priority to store |
| rej_i | input | 1 | Reject strobe |
| rej_num_i | input | NUM_W | Global number being rejected |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Global number being completed |
| replay_i | input | 1 | Replay scan request |
| offer_valid_o | output | 1 | Offer issued this cycle |
| offer_num_o | output | NUM_W | Global interrupt number offered |
| offer_server_o | output | SRV_W | Target server of the offer |
| offer_prio_o | output | PRIO_W | Priority of the offer |
| replay_done_o | output | 1 | One-cycle pulse at scan end |

## Verification
Edge sources are driven with single pulses in three conditions: unmasked, masked and later unmasked, and rejected and then replayed, both unmasked and masked. These cases separate immediate offers, latched masked events and events dropped on a masked replay. Level sources are held high across end-of-interrupt, reject, input toggles and replays. This shows that a re-offer needs both a cleared sent flag and a check trigger. Simultaneous pulses on several edge sources test the ascending one-per-cycle drain. Out-of-range numbers whose low bits alias a live source test the range decode.

// File: rtl/isb_pkg.sv
package isb_pkg;
  typedef struct packed {
    logic mpend;  // edge event seen while masked
    logic rejd;   // edge offer bounced by presenter
    logic asrt;   // level input last seen high
    logic sent;   // level offer outstanding
  } src_stat_t;

  localparam src_stat_t STAT_CLEAR = '0;
endpackage

// File: rtl/isb_src_cell.sv
module isb_src_cell import isb_pkg::*; #(
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              level_i,
  input  logic              irq_i,
  input  logic              cfg_we_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_saved_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              visit_i,
  input  logic              grant_i,
  output logic              queued_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0] saved_o
);
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  src_stat_t         stat_q, stat_d;
  logic [SRV_W-1:0]  srv_d;
  logic [PRIO_W-1:0] prio_d, saved_d;
  logic              offer, recheck, queued_d;

  always_comb begin
    stat_d  = stat_q;
    srv_d   = server_o;
    prio_d  = prio_o;
    saved_d = saved_o;
    offer   = 1'b0;
    recheck = 1'b0;

    if (rej_i) begin
      if (level_i) stat_d.sent = 1'b0;
      else         stat_d.rejd = 1'b1;
    end
    if (eoi_i && level_i) stat_d.sent = 1'b0;

    if (cfg_we_i) begin
      srv_d   = cfg_server_i;
      prio_d  = cfg_prio_i;
      saved_d = cfg_saved_i;
      if (!level_i && stat_d.mpend && (cfg_prio_i != PRIO_OFF)) begin
        stat_d.mpend = 1'b0;
        offer        = 1'b1;
      end
    end

    if (level_i) begin
      recheck     = cfg_we_i | visit_i | (irq_i != stat_q.asrt);
      stat_d.asrt = irq_i;
      if (recheck && (prio_d != PRIO_OFF) && stat_d.asrt && !stat_d.sent) begin
        stat_d.sent = 1'b1;
        offer       = 1'b1;
      end
    end else begin
      if (irq_i) begin
        if (prio_d == PRIO_OFF) stat_d.mpend = 1'b1;
        else                    offer        = 1'b1;
      end
      if (visit_i && stat_d.rejd) begin
        stat_d.rejd = 1'b0;
        if (prio_d != PRIO_OFF) offer = 1'b1;
      end
    end

    queued_d = (queued_o & ~grant_i) | offer;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q   <= STAT_CLEAR;
      server_o <= '0;
      prio_o   <= PRIO_OFF;
      saved_o  <= PRIO_OFF;
      queued_o <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      server_o <= srv_d;
      prio_o   <= prio_d;
      saved_o  <= saved_d;
      queued_o <= queued_d;
    end
  end
endmodule

// File: rtl/isb_lowest_pick.sv
module isb_lowest_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    gnt_o = '0;
    any_o = |req_i;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
    if (any_o) gnt_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/isb_replay_seq.sv
module isb_replay_seq #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         replay_i,
  output logic [N-1:0] visit_o,
  output logic         busy_o,
  output logic         done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] idx_q;

  for (genvar k = 0; k < N; k++) begin : g_visit
    assign visit_o[k] = busy_o && (idx_q == IDX_W'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (replay_i) begin
          busy_o <= 1'b1;
          idx_q  <= '0;
        end
      end else if (idx_q == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank import isb_pkg::*; #(
  parameter int               NUM_SRC  = 8,
  parameter int               SRV_W    = 4,
  parameter int               PRIO_W   = 8,
  parameter int               NUM_W    = 16,
  parameter logic [NUM_W-1:0] BASE_NUM = 16'h1000,
  localparam int              IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] level_mode_i,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SRV_W-1:0]   cfg_server_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic [PRIO_W-1:0]  cfg_saved_i,
  input  logic               rej_i,
  input  logic [NUM_W-1:0]   rej_num_i,
  input  logic               eoi_i,
  input  logic [NUM_W-1:0]   eoi_num_i,
  input  logic               replay_i,
  output logic               offer_valid_o,
  output logic [NUM_W-1:0]   offer_num_o,
  output logic [SRV_W-1:0]   offer_server_o,
  output logic [PRIO_W-1:0]  offer_prio_o,
  output logic               replay_done_o
);
  logic [NUM_SRC-1:0]        queued, grant, visit;
  logic [SRV_W-1:0]          srv_arr   [NUM_SRC];
  logic [PRIO_W-1:0]         prio_arr  [NUM_SRC];
  logic [PRIO_W-1:0]         saved_arr [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] saved_flat;
  logic [IDX_W-1:0]          pick_idx;
  logic                      pick_any, scan_busy;

  // range decode of returned global numbers
  logic [NUM_W-1:0] rej_off, eoi_off;
  logic             rej_hit, eoi_hit;
  logic [IDX_W-1:0] rej_idx, eoi_idx;

  assign rej_off = rej_num_i - BASE_NUM;
  assign eoi_off = eoi_num_i - BASE_NUM;
  assign rej_hit = rej_i && (rej_num_i >= BASE_NUM) && (rej_off < NUM_W'(NUM_SRC));
  assign eoi_hit = eoi_i && (eoi_num_i >= BASE_NUM) && (eoi_off < NUM_W'(NUM_SRC));
  assign rej_idx = rej_off[IDX_W-1:0];
  assign eoi_idx = eoi_off[IDX_W-1:0];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
    isb_src_cell #(
      .SRV_W (SRV_W),
      .PRIO_W(PRIO_W)
    ) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .level_i     (level_mode_i[k]),
      .irq_i       (irq_i[k]),
      .cfg_we_i    (cfg_we_i && (cfg_idx_i == K_IDX)),
      .cfg_server_i(cfg_server_i),
      .cfg_prio_i  (cfg_prio_i),
      .cfg_saved_i (cfg_saved_i),
      .rej_i       (rej_hit && (rej_idx == K_IDX)),
      .eoi_i       (eoi_hit && (eoi_idx == K_IDX)),
      .visit_i     (visit[k]),
      .grant_i     (grant[k]),
      .queued_o    (queued[k]),
      .server_o    (srv_arr[k]),
      .prio_o      (prio_arr[k]),
      .saved_o     (saved_arr[k])
    );
    assign saved_flat[k*PRIO_W +: PRIO_W] = saved_arr[k];
  end

  isb_lowest_pick #(
    .N    (NUM_SRC),
    .IDX_W(IDX_W)
  ) u_pick (
    .req_i(queued),
    .gnt_o(grant),
    .idx_o(pick_idx),
    .any_o(pick_any)
  );

  isb_replay_seq #(
    .N    (NUM_SRC),
    .IDX_W(IDX_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .replay_i(replay_i),
    .visit_o (visit),
    .busy_o  (scan_busy),
    .done_o  (replay_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offer_valid_o  <= 1'b0;
      offer_num_o    <= '0;
      offer_server_o <= '0;
      offer_prio_o   <= '0;
    end else begin
      offer_valid_o <= pick_any;
      if (pick_any) begin
        offer_num_o    <= BASE_NUM + NUM_W'(pick_idx);
        offer_server_o <= srv_arr[pick_idx];
        offer_prio_o   <= prio_arr[pick_idx];
      end
    end
  end
endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
  parameter int               NUM_SRC  = 8,
  parameter int               PRIO_W   = 8,
  parameter int               NUM_W    = 16,
  parameter logic [NUM_W-1:0] BASE_NUM = 16'h1000,
  parameter int               IDX_W    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cfg_we_i,
  input logic [IDX_W-1:0]          cfg_idx_i,
  input logic [PRIO_W-1:0]         cfg_saved_i,
  input logic                      replay_i,
  input logic                      scan_busy_i,
  input logic                      replay_done_i,
  input logic                      offer_valid_i,
  input logic [NUM_W-1:0]          offer_num_i,
  input logic [NUM_SRC*PRIO_W-1:0] saved_flat_i
);
  p_offer_in_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offer_valid_i |-> ((offer_num_i >= BASE_NUM) &&
                       ((offer_num_i - BASE_NUM) < NUM_W'(NUM_SRC))));

  p_done_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_done_i |=> !replay_done_i);

  p_done_ends_scan_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_done_i |-> $past(scan_busy_i));

  p_scan_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_i && !scan_busy_i) |=> scan_busy_i);

  p_saved_stored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (int'(cfg_idx_i) < NUM_SRC)) |=>
      (saved_flat_i[$past(cfg_idx_i)*PRIO_W +: PRIO_W] == $past(cfg_saved_i)));
endmodule

bind irq_source_bank isb_checker #(
  .NUM_SRC (NUM_SRC),
  .PRIO_W  (PRIO_W),
  .NUM_W   (NUM_W),
  .BASE_NUM(BASE_NUM),
  .IDX_W   (IDX_W)
) u_isb_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_idx_i    (cfg_idx_i),
  .cfg_saved_i  (cfg_saved_i),
  .replay_i     (replay_i),
  .scan_busy_i  (scan_busy),
  .replay_done_i(replay_done_o),
  .offer_valid_i(offer_valid_o),
  .offer_num_i  (offer_num_o),
  .saved_flat_i (saved_flat)
);

// File: tb/sim_irq_source_bank.sv
`timescale 1ns/1ps
module sim_irq_source_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  edge_in = '0;
  logic [3:0]  lvl_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_srv = '0;
  logic [7:0]  cfg_prio = '0;
  logic [7:0]  cfg_saved = '0;
  logic        rej = 1'b0;
  logic [15:0] rej_num = '0;
  logic        eoi = 1'b0;
  logic [15:0] eoi_num = '0;
  logic        replay = 1'b0;
  logic        offer_valid;
  logic [15:0] offer_num;
  logic [3:0]  offer_srv;
  logic [7:0]  offer_prio;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int log_n = 0;
  logic [15:0] log_num  [64];
  logic [3:0]  log_srv  [64];
  logic [7:0]  log_prio [64];
  int          log_cyc  [64];

  always #10 clk = ~clk;

  irq_source_bank u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .level_mode_i  (8'hF0),
    .irq_i         ({lvl_in, edge_in}),
    .cfg_we_i      (cfg_we),
    .cfg_idx_i     (cfg_idx),
    .cfg_server_i  (cfg_srv),
    .cfg_prio_i    (cfg_prio),
    .cfg_saved_i   (cfg_saved),
    .rej_i         (rej),
    .rej_num_i     (rej_num),
    .eoi_i         (eoi),
    .eoi_num_i     (eoi_num),
    .replay_i      (replay),
    .offer_valid_o (offer_valid),
    .offer_num_o   (offer_num),
    .offer_server_o(offer_srv),
    .offer_prio_o  (offer_prio),
    .replay_done_o (done)
  );

  always @(negedge clk) begin
    cyc++;
    if (offer_valid) begin
      if (log_n < 64) begin
        log_num[log_n]  = offer_num;
        log_srv[log_n]  = offer_srv;
        log_prio[log_n] = offer_prio;
        log_cyc[log_n]  = cyc;
      end
      log_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_log();
    idle(1);
    log_n = 0;
  endtask

  task automatic cfg(input int idx, input int srv, input int prio, input int saved);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_srv = 4'(srv);
    cfg_prio = 8'(prio); cfg_saved = 8'(saved);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_edge(input logic [3:0] m);
    @(negedge clk); edge_in = m;
    @(negedge clk); edge_in = '0;
  endtask

  task automatic do_reject(input int num);
    @(negedge clk); rej = 1'b1; rej_num = 16'(num);
    @(negedge clk); rej = 1'b0;
  endtask

  task automatic do_eoi(input int num);
    @(negedge clk); eoi = 1'b1; eoi_num = 16'(num);
    @(negedge clk); eoi = 1'b0;
  endtask

  task automatic do_replay();
    @(negedge clk); replay = 1'b1;
    @(negedge clk); replay = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "valid after reset", int'(offer_valid), 0);
    chk("R1", "done after reset", int'(done), 0);
    @(negedge clk); lvl_in[3] = 1'b1;   // source 7, masked, left high
    idle(6);
    chk("R1", "offers from masked level", log_n, 0);
  endtask

  task automatic t_edge();
    clear_log();
    cfg(2, 9, 4, 8'h44);
    @(negedge clk); edge_in = 4'b0100;
    @(negedge clk); edge_in = '0;
    chk("R2", "valid one edge after sample", int'(offer_valid), 0);
    @(negedge clk);
    chk("R2", "valid two edges after sample", int'(offer_valid), 1);
    chk("R2", "number", int'(offer_num), 16'h1002);
    chk("R9", "server", int'(offer_srv), 9);
    chk("R9", "priority", int'(offer_prio), 4);
    @(negedge clk);
    chk("R2", "single offer", int'(offer_valid), 0);
  endtask

  task automatic t_mask_pending();
    clear_log();
    pulse_edge(4'b0010);
    idle(5);
    chk("R3", "masked edge no offer", log_n, 0);
    cfg(1, 2, 8'hFF, 0);
    idle(4);
    chk("R3", "masked rewrite no offer", log_n, 0);
    cfg(1, 2, 7, 0);
    idle(4);
    chk("R3", "unmask offers once", log_n, 1);
    chk("R3", "unmask number", int'(log_num[0]), 16'h1001);
    chk("R3", "unmask server", int'(log_srv[0]), 2);
    chk("R3", "unmask priority", int'(log_prio[0]), 7);
    cfg(1, 2, 7, 0);
    idle(4);
    chk("R3", "pending cleared", log_n, 1);
  endtask

  task automatic t_queue();
    cfg(0, 5, 2, 0);
    cfg(3, 7, 6, 0);
    clear_log();
    pulse_edge(4'b1101);
    idle(6);
    chk("R8", "three offers", log_n, 3);
    chk("R8", "first", int'(log_num[0]), 16'h1000);
    chk("R8", "second", int'(log_num[1]), 16'h1002);
    chk("R8", "third", int'(log_num[2]), 16'h1003);
    chk("R8", "back to back 1", log_cyc[1] - log_cyc[0], 1);
    chk("R8", "back to back 2", log_cyc[2] - log_cyc[1], 1);
    chk("R8", "third server", int'(log_srv[2]), 7);
  endtask

  task automatic t_level();
    clear_log();
    cfg(4, 1, 3, 0);
    idle(4);
    chk("R4", "low level no offer", log_n, 0);
    @(negedge clk); lvl_in[0] = 1'b1;
    idle(8);
    chk("R4", "level offered once", log_n, 1);
    chk("R4", "level number", int'(log_num[0]), 16'h1004);
    chk("R4", "level priority", int'(log_prio[0]), 3);
    do_eoi(16'h1004);
    idle(5);
    chk("R6", "eoi without trigger", log_n, 1);
    @(negedge clk); lvl_in[0] = 1'b0;
    idle(2);
    @(negedge clk); lvl_in[0] = 1'b1;
    idle(5);
    chk("R4", "retoggle reoffers", log_n, 2);
    chk("R4", "retoggle number", int'(log_num[1]), 16'h1004);
  endtask

  task automatic t_reject_replay();
    int n;
    clear_log();
    do_reject(16'h1002);
    do_reject(16'h1004);
    idle(5);
    chk("R5", "reject no offer", log_n, 0);
    @(negedge clk); replay = 1'b1;
    @(negedge clk); replay = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R7", "done latency", n, 9);
    @(negedge clk);
    chk("R7", "done one cycle", int'(done), 0);
    idle(4);
    chk("R7", "replay offers", log_n, 2);
    chk("R7", "replay edge", int'(log_num[0]), 16'h1002);
    chk("R5", "replay level", int'(log_num[1]), 16'h1004);
    do_replay();
    idle(14);
    chk("R7", "second replay quiet", log_n, 2);
  endtask

  task automatic t_eoi_edge();
    clear_log();
    do_eoi(16'h1002);
    idle(4);
    chk("R6", "edge eoi no offer", log_n, 0);
    do_replay();
    idle(14);
    chk("R6", "edge eoi no state", log_n, 0);
    pulse_edge(4'b0100);
    idle(4);
    chk("R6", "edge after eoi", log_n, 1);
  endtask

  task automatic t_range();
    clear_log();
    do_reject(16'h100C);
    do_reject(16'h0FFF);
    do_eoi(16'h100C);
    do_eoi(16'h1008);
    do_replay();
    idle(14);
    chk("R10", "out of range ignored", log_n, 0);
    do_eoi(16'h1004);
    do_replay();
    idle(14);
    chk("R6", "eoi then replay", log_n, 1);
    chk("R6", "eoi replay number", int'(log_num[0]), 16'h1004);
  endtask

  task automatic t_cfg_level();
    clear_log();
    @(negedge clk); lvl_in[1] = 1'b1;
    idle(4);
    chk("R4", "masked level held", log_n, 0);
    cfg(5, 6, 1, 0);
    idle(4);
    chk("R9", "cfg write checks level", log_n, 1);
    chk("R9", "cfg level number", int'(log_num[0]), 16'h1005);
    chk("R9", "cfg level server", int'(log_srv[0]), 6);
    chk("R9", "cfg level priority", int'(log_prio[0]), 1);
  endtask

  task automatic t_lost();
    clear_log();
    do_reject(16'h1002);
    cfg(2, 9, 8'hFF, 0);
    do_replay();
    idle(14);
    chk("R7", "masked replay drops", log_n, 0);
    cfg(2, 9, 4, 0);
    idle(4);
    chk("R7", "dropped stays dropped", log_n, 0);
    pulse_edge(4'b0100);
    idle(4);
    chk("R2", "edge works after drop", log_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_edge();
    t_mask_pending();
    t_queue();
    t_level();
    t_reject_replay();
    t_eoi_edge();
    t_range();
    t_cfg_level();
    t_lost();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule